// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces one pulse-width modulated output per channel. Each channel first divides the input clock by a programmable prescaler. It then counts the prescaled ticks to set the length of a period and the length of the high phase at the start of that period. Software programs every channel through a small memory-mapped bank of two 32-bit words per channel, using a simple single-cycle read/write bus.

Software writes new timing values into a staged copy and then requests that they take effect. The running period always completes before the new values apply, so the output never shows a truncated or stretched pulse. A hardware-cleared request flag tells software when the values have been taken up. Disabling a channel also waits for the end of the running period. The pin is then held low and the divider fields return to fixed values.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and every register word reads as zero.
- R2: Channel c has word A at byte address 8*c and word B at 8*c+4. Word A holds the high count in bits 31:16 and the period divider D in bits 15:0. Word B holds the prescaler P in bits 15:0, the update request in bit 30 and the run enable in bit 31. Its other bits read as zero. Reads return the staged field values.
- R3: A running channel repeats a period of (P+1)*(D+1) clock cycles. The output is high for the first H*(P+1) cycles of each period and low for the rest.
- R4: With H = 0 the output stays low for the whole period. With H >= D+1 it stays high for the whole period, including H = 0xFFFF.
- R5: Writing enable=1 to an idle channel starts a period on the clock edge after the write, using the staged values. The output is high from that edge on when H > 0, and the update flag then reads 0.
- R6: Writes that do not request an update leave the running waveform unchanged.
- R7: An update request takes effect only at the end of the running period, which completes with the old values. The flag reads 1 until the new values apply and 0 afterwards.
- R8: Writing 0 to the update bit does not cancel a pending request.
- R9: Clearing enable lets the running period finish, then holds the output low. The staged P then reads 0x0000, the staged D reads 0x0001, H is kept, and enable and update read 0.
- R10: The channels run independently with different settings at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when set, read when clear |
| bus_addr | input | ADDR_W (5) | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pwm_out | output | NCH (4) | One modulated output per channel |

## Verification
The bench builds the block with its defaults: four channels and 16-bit fields. That gives a 5-bit address space in which every channel decode is reached, and it makes the saturated high count 0xFFFF a legal value. Small random prescaler and divider values keep each period short. Many complete waveforms can then be measured, and an update can be placed inside a running period. A long 256-cycle period is used to hold an update pending while the cancel attempt is made.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned FLD_W   = 16;
  localparam int unsigned UPD_BIT = 30;
  localparam int unsigned EN_BIT  = 31;
  localparam logic [FLD_W-1:0] PRE_AFTER_STOP = 16'h0000;
  localparam logic [FLD_W-1:0] DIV_AFTER_STOP = 16'h0001;

  typedef struct packed {
    logic [FLD_W-1:0] hi;
    logic [FLD_W-1:0] div;
    logic [FLD_W-1:0] pre;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_bank_chregs.sv
module pwm_bank_chregs
  import pwm_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        hw_start,
  input  logic        hw_apply,
  input  logic        hw_stop,
  output pwm_cfg_t    stg,
  output logic        en,
  output logic        upd,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi
);
  pwm_cfg_t stg_n;
  logic     en_n, upd_n, ld;
  logic     unused_bits;

  assign unused_bits = ^wdata[29:16];
  assign ld = wr_lo | wr_hi | hw_start | hw_apply | hw_stop;

  always_comb begin
    stg_n = stg;
    en_n  = en;
    upd_n = upd;
    if (hw_start || hw_apply) upd_n = 1'b0;
    if (hw_stop) begin
      stg_n.pre = PRE_AFTER_STOP;
      stg_n.div = DIV_AFTER_STOP;
      upd_n     = 1'b0;
    end
    if (wr_lo) begin
      stg_n.hi  = wdata[31:16];
      stg_n.div = wdata[15:0];
    end
    if (wr_hi) begin
      stg_n.pre = wdata[15:0];
      en_n      = wdata[EN_BIT];
      if (wdata[UPD_BIT]) upd_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
      en  <= 1'b0;
      upd <= 1'b0;
    end else if (ld) begin
      stg <= stg_n;
      en  <= en_n;
      upd <= upd_n;
    end
  end

  assign rd_lo = {stg.hi, stg.div};
  assign rd_hi = {en, upd, 14'd0, stg.pre};
endmodule

// File: rtl/pwm_bank_chcore.sv
module pwm_bank_chcore
  import pwm_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pwm_cfg_t stg,
  input  logic     en,
  input  logic     upd,
  output logic     pwm,
  output logic     running,
  output logic     period_end,
  output logic     start,
  output logic     apply,
  output logic     stop
);
  pwm_cfg_t         act, act_n;
  logic [FLD_W-1:0] pre_cnt, pre_cnt_n, per_cnt, per_cnt_n;
  logic             run_n, tick, ce;

  assign tick       = (pre_cnt == act.pre);
  assign period_end = running & tick & (per_cnt == act.div);
  assign start      = ~running & en;
  assign apply      = period_end & en & upd;
  assign stop       = period_end & ~en;
  assign ce         = running | en;

  always_comb begin
    run_n     = running;
    act_n     = act;
    pre_cnt_n = pre_cnt;
    per_cnt_n = per_cnt;
    if (start) begin
      run_n     = 1'b1;
      act_n     = stg;
      pre_cnt_n = '0;
      per_cnt_n = '0;
    end else if (period_end) begin
      pre_cnt_n = '0;
      per_cnt_n = '0;
      if (stop)  run_n = 1'b0;
      if (apply) act_n = stg;
    end else if (running) begin
      if (tick) begin
        pre_cnt_n = '0;
        per_cnt_n = per_cnt + 1'b1;
      end else begin
        pre_cnt_n = pre_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      act     <= '0;
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (ce) begin
      running <= run_n;
      act     <= act_n;
      pre_cnt <= pre_cnt_n;
      per_cnt <= per_cnt_n;
    end
  end

  assign pwm = running & (per_cnt < act.hi);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = $clog2(NCH * 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int unsigned CH_W = ADDR_W - 3;

  logic [1:0]      rst_q;
  logic            rst_core_n;
  logic [CH_W-1:0] ch_idx;
  logic            hi_sel;
  logic            unused_lsb;
  logic [NCH-1:0]  run_vec, pend_vec, en_vec, upd_vec;
  logic [31:0]     rd_lo [NCH];
  logic [31:0]     rd_hi [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  assign ch_idx     = bus_addr[ADDR_W-1:3];
  assign hi_sel     = bus_addr[2];
  assign unused_lsb = ^bus_addr[1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_cfg_t stg;
    logic     wr_lo, wr_hi, st, ap, sp;

    assign wr_lo = bus_sel & bus_we & (ch_idx == CH_W'(i)) & ~hi_sel;
    assign wr_hi = bus_sel & bus_we & (ch_idx == CH_W'(i)) &  hi_sel;

    pwm_bank_chregs u_regs (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wdata   (bus_wdata),
      .hw_start(st),
      .hw_apply(ap),
      .hw_stop (sp),
      .stg     (stg),
      .en      (en_vec[i]),
      .upd     (upd_vec[i]),
      .rd_lo   (rd_lo[i]),
      .rd_hi   (rd_hi[i])
    );

    pwm_bank_chcore u_core (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .stg       (stg),
      .en        (en_vec[i]),
      .upd       (upd_vec[i]),
      .pwm       (pwm_out[i]),
      .running   (run_vec[i]),
      .period_end(pend_vec[i]),
      .start     (st),
      .apply     (ap),
      .stop      (sp)
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_idx == CH_W'(i)) bus_rdata = hi_sel ? rd_hi[i] : rd_lo[i];
    end
  end
endmodule

// File: rtl/pwm_bank_checks.sv
module pwm_bank_checks #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] run_vec,
  input logic [NCH-1:0] pend_vec,
  input logic [NCH-1:0] en_vec,
  input logic [NCH-1:0] upd_vec
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R3: a high phase begins only at a period boundary or at a start
    p_rise_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[i]) |-> ($past(pend_vec[i]) || !$past(run_vec[i])));
    // R5: an enabled idle channel is running one edge later
    p_start_next_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_vec[i] && en_vec[i]) |=> run_vec[i]);
    // R7: the update flag drops only at a boundary or at a start
    p_upd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(upd_vec[i]) |-> ($past(pend_vec[i]) || !$past(run_vec[i])));
    // R9: a channel stops only at the end of a period with enable clear
    p_stop_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_vec[i]) |-> ($past(pend_vec[i]) && !$past(en_vec[i])));
  end
endmodule

bind pwm_bank pwm_bank_checks #(.NCH(NCH)) u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwm_out (pwm_out),
  .run_vec (run_vec),
  .pend_vec(pend_vec),
  .en_vec  (en_vec),
  .upd_vec (upd_vec)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int NCH = 4;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] pwm_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_bank u_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  function automatic int exp_period(int p, int d); return (p + 1) * (d + 1); endfunction
  function automatic int exp_high(int p, int d, int h);
    return ((h > d + 1) ? d + 1 : h) * (p + 1);
  endfunction
  function automatic logic [31:0] w_lo(int h, int d); return {16'(h), 16'(d)}; endfunction
  function automatic logic [31:0] w_hi(bit e, bit u, int p);
    return {e, u, 14'd0, 16'(p)};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic wait_upd_clear(input int c);
    logic [31:0] d;
    for (int k = 0; k < 3000; k++) begin
      bus_rd(8 * c + 4, d);
      if (!d[30]) break;
    end
  endtask

  task automatic wait_rise(input int c);
    int g = 0;
    @(negedge clk);
    while (pwm_out[c] && g < 5000) begin @(negedge clk); g++; end
    while (!pwm_out[c] && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic measure(input int c, output int hi, output int per);
    int lo = 0;
    hi = 0;
    wait_rise(c);
    while (pwm_out[c] && hi < 5000) begin hi++; @(negedge clk); end
    while (!pwm_out[c] && lo < 5000) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic count_high(input int c, input int n, output int ones);
    ones = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (pwm_out[c]) ones++; end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int h, p, ones;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 outputs", int'(pwm_out), 0);
    for (int a = 0; a < 32; a += 4) begin
      bus_rd(a, d);
      chk("R1 register", int'(d), 0);
    end

    // R5 start from idle on channel 0, then R2 readback and R3 shape
    bus_wr(0, w_lo(3, 5));
    bus_wr(4, w_hi(1, 1, 2));
    chk("R5 low before start edge", int'(pwm_out[0]), 0);
    @(negedge clk);
    chk("R5 high after start edge", int'(pwm_out[0]), 1);
    bus_rd(4, d);
    chk("R5 update cleared", int'(d[30]), 0);
    chk("R2 word B layout", int'(d), int'(w_hi(1, 0, 2)));
    bus_rd(0, d);
    chk("R2 word A layout", int'(d), int'(w_lo(3, 5)));
    measure(0, h, p);
    chk("R3 period ch0", p, exp_period(2, 5));
    chk("R3 high ch0", h, exp_high(2, 5, 3));

    // R6 staged write without update leaves ch1 waveform alone
    bus_wr(8, w_lo(6, 9));
    bus_wr(12, w_hi(1, 0, 1));
    bus_wr(8, w_lo(2, 4));
    measure(1, h, p);
    chk("R6 period kept", p, exp_period(1, 9));
    chk("R6 high kept", h, exp_high(1, 9, 6));

    // R7 update issued at a rising edge: current period completes first
    wait_rise(1);
    bus_sel = 1; bus_we = 1; bus_addr = AW'(12); bus_wdata = w_hi(1, 1, 0);
    h = 0;
    do begin
      h++; @(negedge clk); bus_sel = 0; bus_we = 0;
    end while (pwm_out[1] && h < 5000);
    chk("R7 old high completes", h, exp_high(1, 9, 6));
    bus_rd(12, d);
    chk("R7 flag pending", int'(d[30]), 1);
    measure(1, h, p);
    chk("R7 new period", p, exp_period(0, 4));
    chk("R7 new high", h, exp_high(0, 4, 2));
    bus_rd(12, d);
    chk("R7 flag cleared", int'(d[30]), 0);

    // R10 two channels with different settings at once
    bus_wr(16, w_lo(1, 2));
    bus_wr(20, w_hi(1, 0, 0));
    measure(2, h, p);
    chk("R10 ch2 period", p, exp_period(0, 2));
    measure(0, h, p);
    chk("R10 ch0 period", p, exp_period(2, 5));
    chk("R10 ch0 high", h, exp_high(2, 5, 3));

    // R4 duty extremes on channel 3
    bus_wr(24, w_lo(0, 3));
    bus_wr(28, w_hi(1, 0, 0));
    count_high(3, 20, ones);
    chk("R4 zero high", ones, 0);
    bus_wr(24, w_lo(4, 3));
    bus_wr(28, w_hi(1, 1, 0));
    wait_upd_clear(3);
    count_high(3, 20, ones);
    chk("R4 full high", ones, 20);
    bus_wr(24, w_lo(16'hFFFF, 3));
    bus_wr(28, w_hi(1, 1, 0));
    wait_upd_clear(3);
    count_high(3, 20, ones);
    chk("R4 saturated high", ones, 20);

    // R8 a write with update=0 does not cancel a pending request
    bus_wr(24, w_lo(8, 15));
    bus_wr(28, w_hi(1, 1, 15));
    wait_upd_clear(3);
    wait_rise(3);
    bus_wr(24, w_lo(5, 9));
    bus_wr(28, w_hi(1, 1, 3));
    bus_wr(28, w_hi(1, 0, 3));
    bus_rd(28, d);
    chk("R8 still pending", int'(d[30]), 1);
    wait_upd_clear(3);
    measure(3, h, p);
    chk("R8 applied period", p, exp_period(3, 9));
    chk("R8 applied high", h, exp_high(3, 9, 5));

    // R9 disable at a rising edge finishes the period
    wait_rise(3);
    bus_sel = 1; bus_we = 1; bus_addr = AW'(28); bus_wdata = w_hi(0, 0, 3);
    h = 0;
    do begin
      h++; @(negedge clk); bus_sel = 0; bus_we = 0;
    end while (pwm_out[3] && h < 5000);
    chk("R9 last high completes", h, exp_high(3, 9, 5));
    count_high(3, 100, ones);
    chk("R9 held low", ones, 0);
    bus_rd(24, d);
    chk("R9 divider reset", int'(d[15:0]), 1);
    chk("R9 high kept", int'(d[31:16]), 5);
    bus_rd(28, d);
    chk("R9 word B cleared", int'(d), 0);

    // R3 random settings on channel 2 through updates
    for (int it = 0; it < 8; it++) begin
      int rp, rd, rh;
      rp = int'($urandom % 4);
      rd = 1 + int'($urandom % 7);
      rh = 1 + int'($urandom % rd);
      bus_wr(16, w_lo(rh, rd));
      bus_wr(20, w_hi(1, 1, rp));
      wait_upd_clear(2);
      measure(2, h, p);
      chk("R3 random period", p, exp_period(rp, rd));
      chk("R3 random high", h, exp_high(rp, rd, rh));
    end

    finish_run();
  end
endmodule